// File: doc/BRIEF.md
# Dual-Issue Dispatch Arbiter

This block sits between the bottom of an in-order instruction queue and the execution units. Each cycle it looks at the two oldest decoded entries, each tagged with a valid bit, a target unit class and a flag saying whether it writes a destination register. It decides which of them leave the queue this cycle.

An entry may leave only if four things hold. Its target unit, or that unit's reservation station, must have room. A completion queue entry must be free for it. If it writes a result, a rename register must be free for it. Every older entry must also be leaving in the same cycle. An entry whose source operands are not yet ready still leaves, because it is parked in the unit's reservation station. For that reason operand readiness is not an input.

The decision is purely combinational from the inputs. The queue shifts by the reported count, the rename and completion allocators take the reported request counts, and each unit is told whether it receives an instruction. The clock and reset are used only to sample the built-in checks.

Top module: `dsp_dispatch_arb`

## Requirements
- R1: At most two entries are issued per cycle, from slots 0 and 1. `issue_cnt` equals the number of asserted `issue` bits, and `cq_alloc_cnt` equals `issue_cnt`.
- R2: Slot 1 is issued only in a cycle where slot 0 is issued (program order).
- R3: An entry is issued only if bit `c` of `unit_rdy` is 1, where `c` is its unit class code. The codes are 0 integer unit 0, 1 integer unit 1, 2 floating point, 3 system register, 4 load/store. Bits of `slot_unit` for slot k are `[3k+2:3k]`.
- R4: If both slots target the same unit class, slot 1 is not issued, even when that unit is ready.
- R5: Each issued entry takes one completion entry. Slot k (k = 0, 1) issues only if `cq_free >= k+1`.
- R6: Only entries with their `slot_dest` bit set need a rename register. Slot k issues only if `ren_free` covers the dest flags of slots 0..k together. `ren_alloc_cnt` is the number of issued entries with a dest flag. An entry without a dest flag issues even with `ren_free = 0`.
- R7: An entry whose `slot_vld` bit is 0 is never issued and requests nothing. When slot 0 is empty, slot 1 is not issued.
- R8: An entry with an undefined class code (5, 6 or 7) is never issued.
- R9: `unit_grant[c]` is 1 exactly when an issued entry targets class `c`, so the number of set grant bits equals `issue_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling the built-in checks |
| rst_n | input | 1 | Active-low reset; disables the checks |
| slot_vld | input | 2 | Entry valid per slot, bit k for slot k |
| slot_unit | input | 6 | Unit class code per slot, 3 bits each |
| slot_dest | input | 2 | Entry writes a destination register, per slot |
| unit_rdy | input | 5 | Unit or its reservation station can accept, per class |
| ren_free | input | 3 | Number of free rename registers |
| cq_free | input | 3 | Number of free completion queue entries |
| issue | output | 2 | Issue strobe per slot |
| issue_cnt | output | 2 | Entries issued this cycle (queue shift amount) |
| ren_alloc_cnt | output | 2 | Rename registers requested this cycle |
| cq_alloc_cnt | output | 2 | Completion entries requested this cycle |
| unit_grant | output | 5 | Unit class receiving an instruction this cycle |

## Verification
There is no state to corrupt, so a wrong gating term appears in the same cycle as a bad `issue` pattern. Examples are slot 1 leaving alone, two grants for one class, or more completion or rename requests than free entries. The queue would then shift by the wrong amount at once. The sweeps cover every pair of class codes and every combination of completion and rename counts, so a dropped or mis-shifted comparison shows up at the ports on the very vector that exercises it.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int UNIT_CNT = 5;
  localparam int UCODE_W  = 3;

  typedef enum logic [UCODE_W-1:0] {
    U_INT0 = 3'd0,
    U_INT1 = 3'd1,
    U_FPU  = 3'd2,
    U_SYSR = 3'd3,
    U_LDST = 3'd4
  } unit_e;

  typedef logic [UNIT_CNT-1:0] umask_t;

endpackage

// File: rtl/dsp_unit_dec.sv
module dsp_unit_dec
  import dsp_pkg::*;
(
  input  logic [UCODE_W-1:0] code,
  output umask_t             mask,
  output logic               legal
);

  // one-hot of the class code; codes beyond the last unit give an empty mask
  always_comb begin
    mask = '0;
    for (int u = 0; u < UNIT_CNT; u++) begin
      if (code == UCODE_W'(u)) mask[u] = 1'b1;
    end
  end

  assign legal = |mask;

endmodule

// File: rtl/dsp_slot_gate.sv
module dsp_slot_gate
  import dsp_pkg::*;
#(
  parameter int SLOT   = 0,
  parameter int REN_W  = 3,
  parameter int CQ_W   = 3,
  parameter int NEED_W = 2
) (
  input  logic              prev_ok,   // every older slot issues
  input  logic              vld,
  input  logic              legal,
  input  umask_t            mask,
  input  umask_t            older,     // units claimed by older slots
  input  umask_t            unit_rdy,
  input  logic [REN_W-1:0]  ren_free,
  input  logic [CQ_W-1:0]   cq_free,
  input  logic [NEED_W-1:0] ren_need,  // dest flags of slots 0..SLOT
  output logic              ok
);

  logic unit_free;
  logic no_clash;
  logic cq_room;
  logic ren_room;

  always_comb begin
    unit_free = |(mask & unit_rdy);
    no_clash  = ~|(mask & older);
    cq_room   = int'(cq_free) >= SLOT + 1;
    ren_room  = int'(ren_free) >= int'(ren_need);
    ok        = prev_ok & vld & legal & unit_free & no_clash & cq_room & ren_room;
  end

endmodule

// File: rtl/dsp_tally.sv
module dsp_tally
  import dsp_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int CNT_W   = 2
) (
  input  logic [ISSUE_W-1:0]          issue,
  input  logic [ISSUE_W-1:0]          dest,
  input  umask_t [ISSUE_W-1:0]        masks,
  output logic [CNT_W-1:0]            issue_cnt,
  output logic [CNT_W-1:0]            ren_cnt,
  output umask_t                      grant
);

  always_comb begin
    issue_cnt = '0;
    ren_cnt   = '0;
    grant     = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      issue_cnt = issue_cnt + CNT_W'(issue[k]);
      ren_cnt   = ren_cnt + CNT_W'(issue[k] & dest[k]);
      if (issue[k]) grant = grant | masks[k];
    end
  end

endmodule

// File: rtl/dsp_dispatch_arb.sv
module dsp_dispatch_arb
  import dsp_pkg::*;
#(
  parameter  int ISSUE_W = 2,
  parameter  int REN_W   = 3,
  parameter  int CQ_W    = 3,
  localparam int CNT_W   = $clog2(ISSUE_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ISSUE_W-1:0]         slot_vld,
  input  logic [ISSUE_W*UCODE_W-1:0] slot_unit,
  input  logic [ISSUE_W-1:0]         slot_dest,
  input  logic [UNIT_CNT-1:0]        unit_rdy,
  input  logic [REN_W-1:0]           ren_free,
  input  logic [CQ_W-1:0]            cq_free,
  output logic [ISSUE_W-1:0]         issue,
  output logic [CNT_W-1:0]           issue_cnt,
  output logic [CNT_W-1:0]           ren_alloc_cnt,
  output logic [CNT_W-1:0]           cq_alloc_cnt,
  output logic [UNIT_CNT-1:0]        unit_grant
);

  umask_t [ISSUE_W-1:0]     masks;
  umask_t [ISSUE_W-1:0]     older;
  logic   [ISSUE_W-1:0]     legal;
  logic   [ISSUE_W-1:0][CNT_W-1:0] need;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    logic prev;

    dsp_unit_dec u_dec (
      .code  (slot_unit[k*UCODE_W +: UCODE_W]),
      .mask  (masks[k]),
      .legal (legal[k])
    );

    if (k == 0) begin : g_head
      assign prev     = 1'b1;
      assign older[k] = '0;
      assign need[k]  = CNT_W'(slot_dest[k]);
    end else begin : g_tail
      assign prev     = issue[k-1];
      assign older[k] = older[k-1] | masks[k-1];
      assign need[k]  = need[k-1] + CNT_W'(slot_dest[k]);
    end

    dsp_slot_gate #(
      .SLOT   (k),
      .REN_W  (REN_W),
      .CQ_W   (CQ_W),
      .NEED_W (CNT_W)
    ) u_gate (
      .prev_ok  (prev),
      .vld      (slot_vld[k]),
      .legal    (legal[k]),
      .mask     (masks[k]),
      .older    (older[k]),
      .unit_rdy (unit_rdy),
      .ren_free (ren_free),
      .cq_free  (cq_free),
      .ren_need (need[k]),
      .ok       (issue[k])
    );

    if (k > 0) begin : g_order_chk
      p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue[k] |-> issue[k-1]);
    end
  end

  dsp_tally #(
    .ISSUE_W (ISSUE_W),
    .CNT_W   (CNT_W)
  ) u_tally (
    .issue     (issue),
    .dest      (slot_dest),
    .masks     (masks),
    .issue_cnt (issue_cnt),
    .ren_cnt   (ren_alloc_cnt),
    .grant     (unit_grant)
  );

  assign cq_alloc_cnt = issue_cnt;

  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue) == int'(issue_cnt));

  p_unit_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_grant & ~unit_rdy) == '0);

  p_cq_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cq_alloc_cnt) <= int'(cq_free));

  p_ren_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ren_alloc_cnt) <= int'(ren_free));

  p_valid_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue & ~slot_vld) == '0);

  p_grant_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unit_grant) == int'(issue_cnt));

endmodule

// File: tb/dsp_dispatch_arb_test.sv
module dsp_dispatch_arb_test;
  import dsp_pkg::*;

  localparam int CLK_P = 10;

  localparam logic [2:0] I0 = U_INT0;
  localparam logic [2:0] I1 = U_INT1;
  localparam logic [2:0] FP = U_FPU;
  localparam logic [2:0] SY = U_SYSR;
  localparam logic [2:0] LS = U_LDST;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] slot_vld;
  logic [5:0] slot_unit;
  logic [1:0] slot_dest;
  logic [4:0] unit_rdy;
  logic [2:0] ren_free;
  logic [2:0] cq_free;
  logic [1:0] issue;
  logic [1:0] issue_cnt;
  logic [1:0] ren_alloc_cnt;
  logic [1:0] cq_alloc_cnt;
  logic [4:0] unit_grant;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dsp_dispatch_arb uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_vld      (slot_vld),
    .slot_unit     (slot_unit),
    .slot_dest     (slot_dest),
    .unit_rdy      (unit_rdy),
    .ren_free      (ren_free),
    .cq_free       (cq_free),
    .issue         (issue),
    .issue_cnt     (issue_cnt),
    .ren_alloc_cnt (ren_alloc_cnt),
    .cq_alloc_cnt  (cq_alloc_cnt),
    .unit_grant    (unit_grant)
  );

  // {req[4], vld[2], u0[3], u1[3], dest[2], rdy[5], ren[3], cq[3], exp_issue[2], exp_ren[2], exp_grant[5]}
  localparam int NV = 19;
  localparam logic [33:0] VEC [NV] = '{
    {4'd1, 2'b11, I0, I1, 2'b11, 5'b11111, 3'd4, 3'd4, 2'b11, 2'd2, 5'b00011}, // R1 dual issue
    {4'd4, 2'b11, I0, I0, 2'b11, 5'b11111, 3'd4, 3'd4, 2'b01, 2'd1, 5'b00001}, // R4 same unit
    {4'd4, 2'b11, LS, LS, 2'b00, 5'b11111, 3'd4, 3'd4, 2'b01, 2'd0, 5'b10000}, // R4 load/store pair
    {4'd2, 2'b11, FP, I0, 2'b11, 5'b11011, 3'd4, 3'd4, 2'b00, 2'd0, 5'b00000}, // R2 older blocked
    {4'd3, 2'b11, SY, FP, 2'b11, 5'b11011, 3'd4, 3'd4, 2'b01, 2'd1, 5'b01000}, // R3 younger unit busy
    {4'd5, 2'b11, I0, LS, 2'b11, 5'b11111, 3'd4, 3'd1, 2'b01, 2'd1, 5'b00001}, // R5 one cq entry
    {4'd5, 2'b11, I0, LS, 2'b11, 5'b11111, 3'd4, 3'd0, 2'b00, 2'd0, 5'b00000}, // R5 no cq entry
    {4'd6, 2'b11, I0, I1, 2'b11, 5'b11111, 3'd1, 3'd4, 2'b01, 2'd1, 5'b00001}, // R6 one rename
    {4'd6, 2'b11, LS, SY, 2'b00, 5'b11111, 3'd0, 3'd4, 2'b11, 2'd0, 5'b11000}, // R6 no dest needed
    {4'd6, 2'b11, LS, I0, 2'b10, 5'b11111, 3'd1, 3'd4, 2'b11, 2'd1, 5'b10001}, // R6 only younger dest
    {4'd6, 2'b11, I0, I1, 2'b01, 5'b11111, 3'd0, 3'd4, 2'b00, 2'd0, 5'b00000}, // R6 none free
    {4'd7, 2'b10, I0, I1, 2'b11, 5'b11111, 3'd4, 3'd4, 2'b00, 2'd0, 5'b00000}, // R7 slot 0 empty
    {4'd7, 2'b01, FP, I1, 2'b11, 5'b11111, 3'd4, 3'd4, 2'b01, 2'd1, 5'b00100}, // R7 slot 1 empty
    {4'd7, 2'b00, I0, I1, 2'b11, 5'b11111, 3'd4, 3'd4, 2'b00, 2'd0, 5'b00000}, // R7 both empty
    {4'd8, 2'b11, 3'd5, I0, 2'b00, 5'b11111, 3'd4, 3'd4, 2'b00, 2'd0, 5'b00000}, // R8 bad older code
    {4'd8, 2'b11, I1, 3'd7, 2'b00, 5'b11111, 3'd4, 3'd4, 2'b01, 2'd0, 5'b00010}, // R8 bad younger code
    {4'd9, 2'b11, FP, SY, 2'b01, 5'b11111, 3'd4, 3'd4, 2'b11, 2'd1, 5'b01100}, // R9 grants
    {4'd5, 2'b11, I1, FP, 2'b11, 5'b11111, 3'd2, 3'd2, 2'b11, 2'd2, 5'b00110}, // R5 exact cover
    {4'd1, 2'b11, LS, FP, 2'b11, 5'b11111, 3'd7, 3'd7, 2'b11, 2'd2, 5'b10100}  // R1 max resources
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [2:0] a, input logic [2:0] b,
                       input logic [1:0] d, input logic [4:0] r, input logic [2:0] rn,
                       input logic [2:0] cq);
    @(negedge clk);
    slot_vld  = v;
    slot_unit = {b, a};
    slot_dest = d;
    unit_rdy  = r;
    ren_free  = rn;
    cq_free   = cq;
    #(CLK_P/4);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    slot_vld  = '0;
    slot_unit = '0;
    slot_dest = '0;
    unit_rdy  = '0;
    ren_free  = '0;
    cq_free   = '0;
    repeat (2) @(posedge clk);
    #(CLK_P/4);
    // idle state with everything empty (R7)
    chk(7, "idle issue", int'(issue), 0);
    chk(7, "idle grant", int'(unit_grant), 0);
    chk(7, "idle rename req", int'(ren_alloc_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [33:0] e;
      int rq;
      int ei;
      e  = VEC[i];
      rq = int'(e[33:30]);
      drive(e[29:28], e[27:25], e[24:22], e[21:20], e[19:15], e[14:12], e[11:9]);
      ei = int'(e[8:7]);
      chk(rq, $sformatf("vec %0d issue", i), int'(issue), ei);
      chk(1, $sformatf("vec %0d issue_cnt", i), int'(issue_cnt), int'(e[8]) + int'(e[7]));
      chk(5, $sformatf("vec %0d cq req", i), int'(cq_alloc_cnt), int'(e[8]) + int'(e[7]));
      chk(6, $sformatf("vec %0d rename req", i), int'(ren_alloc_cnt), int'(e[6:5]));
      chk(9, $sformatf("vec %0d grant", i), int'(unit_grant), int'(e[4:0]));
    end

    // every pair of class codes with ample resources (R4, R8, R9)
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        bit e0;
        bit e1;
        int eg;
        e0 = (a < 5);
        e1 = e0 && (b < 5) && (a != b);
        eg = (e0 ? (1 << a) : 0) | (e1 ? (1 << b) : 0);
        drive(2'b11, 3'(a), 3'(b), 2'b00, 5'b11111, 3'd7, 3'd7);
        chk(4, $sformatf("pair %0d,%0d issue", a, b), int'(issue), {30'd0, e1, e0});
        chk(9, $sformatf("pair %0d,%0d grant", a, b), int'(unit_grant), eg);
      end
    end

    // completion and rename counts, both slots writing a result (R5, R6)
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) begin
        int n;
        n = 2;
        if (c < n) n = c;
        if (r < n) n = r;
        drive(2'b11, I0, I1, 2'b11, 5'b11111, 3'(r), 3'(c));
        chk(5, $sformatf("cq %0d ren %0d count", c, r), int'(issue_cnt), n);
        chk(6, $sformatf("cq %0d ren %0d rename req", c, r), int'(ren_alloc_cnt), n);
      end
    end

    // only one unit ready at a time; slot 1 targets the next class (R3)
    for (int u = 0; u < 5; u++) begin
      drive(2'b11, 3'(u), 3'((u + 1) % 5), 2'b00, 5'(1 << u), 3'd7, 3'd7);
      chk(3, $sformatf("ready %0d issue", u), int'(issue), 1);
      chk(3, $sformatf("ready %0d grant", u), int'(unit_grant), 1 << u);
    end

    // slot 1 alone would fit but slot 0's unit is busy (R2)
    drive(2'b11, LS, I1, 2'b00, 5'b01111, 3'd7, 3'd7);
    chk(2, "order hold issue", int'(issue), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule